// File: doc/BRIEF.md
# I2C Byte-Memory Target Interface

This block is the serial front end of a byte-organised nonvolatile memory that sits on a two-wire I2C bus as a target. It oversamples the bus clock and data lines with the system clock and recognises start and stop conditions. It checks the first byte of each transaction against a fixed device-type code and three board-level select pins. It then either takes a two-byte memory address followed by any number of data bytes, or streams stored bytes back to the host for as long as the host keeps acknowledging.

The storage itself lives outside the block. It is reached through a synchronous byte port. A write is a one-cycle pulse that carries the address and the data. A read is a one-cycle request, and the byte comes back on the following clock. The block only ever pulls SDA low, through an output enable, so it fits an open-drain pad. A start or a stop seen at any point drops the operation in progress.

Top module: `i2c_mem_target`

## Requirements
- R1: A start (SDA falling while SCL is high) puts the block into address-byte reception. A stop (SDA rising while SCL is high) ends the transaction, and `sda_oe_o` is low on the cycle after the stop is detected.
- R2: A start or stop that arrives mid-byte or mid-transaction aborts it with no memory write. After an aborting start the next byte is again treated as a device address.
- R3: The device address byte is acknowledged only when bits 7..4 equal 4'b1010 and bits 3..1 equal `sel_i`. On a mismatch the byte is not acknowledged, and every later byte up to the next start is neither acknowledged nor written.
- R4: After a matching address byte with bit 0 = 0, the next two bytes set the memory pointer (high byte first, bit 7 of the high byte ignored). Every later byte is acknowledged and written as one `mem_wr_o` pulse with `mem_addr_o` equal to the pointer.
- R5: After a matching address byte with bit 0 = 1, the block sends bytes MSB first from successive addresses while the host acknowledges. A host no-acknowledge ends the read with SDA released.
- R6: The pointer advances by one after each byte written or fetched, and it wraps from 0x7FFF to 0x0000.
- R7: A read that starts without a preceding address phase begins at the current pointer, which is the address after the last byte written or fetched.
- R8: SDA is only driven low, and `sda_oe_o` is only asserted while SCL is low.
- R9: `mem_wr_o` and `mem_rd_o` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sel_i | input | 3 | Board select pins compared with address bits 3..1 |
| sda_oe_o | output | 1 | When high, the pad pulls SDA low |
| mem_addr_o | output | AW | Memory byte address for a read or write |
| mem_wr_o | output | 1 | One-cycle write strobe |
| mem_wdata_o | output | 8 | Write data |
| mem_rd_o | output | 1 | One-cycle read request |
| mem_rdata_i | input | 8 | Read data, valid the cycle after the request |

## Verification
The assertions check on every clock the rules that are local in time. SDA is released right after any start or stop. The pad enable only rises while SCL is low. The memory strobes are single pulses that never overlap. Address matching, pointer loading, increment and wrap, current-address reads, the host no-acknowledge and the abort paths span whole byte sequences, so only the bench's bus scenarios show them: it compares every write against a scoreboard and every returned byte and acknowledge bit against expected values.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;
    localparam int SEL_W = 3;
    localparam logic [3:0] DEV_TYPE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_DEV  = 3'd1,
        ST_AHI  = 3'd2,
        ST_ALO  = 3'd3,
        ST_WR   = 3'd4,
        ST_RD   = 3'd5
    } tgt_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] stg_q;

    // lines idle high, so reset to ones
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '1;
        else        stg_q <= {stg_q[STAGES-2:0], d_i};
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise = scl_s & ~scl_q;
    assign scl_fall = ~scl_s & scl_q;
    assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_dev_match.sv
module i2c_dev_match
    import i2c_mem_pkg::*;
(
    input  logic [7:0]       byte_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             hit_o,
    output logic             rd_o
);
    assign hit_o = (byte_i[7:SEL_W+1] == DEV_TYPE) && (byte_i[SEL_W:1] == sel_i);
    assign rd_o  = byte_i[0];
endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
    import i2c_mem_pkg::*;
#(
    parameter int AW          = 15,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             sda_oe_o,
    output logic [AW-1:0]    mem_addr_o,
    output logic             mem_wr_o,
    output logic [7:0]       mem_wdata_o,
    output logic             mem_rd_o,
    input  logic [7:0]       mem_rdata_i
);
    localparam int HI_W = AW - 8;

    typedef struct packed {
        tgt_state_e    st;
        logic [3:0]    bcnt;
        logic          in_ack;
        logic          dev_ack;
        logic [7:0]    sh;
        logic [7:0]    txb;
        logic          oe;
        logic [AW-1:0] ptr;
        logic [AW-1:0] maddr;
        logic [7:0]    wdata;
        logic          wr;
        logic          rd;
        logic          rdv;
    } regs_t;

    logic [1:0] sync_s;
    logic       scl_s, sda_s;
    logic       scl_rise, scl_fall, start_ev, stop_ev;
    logic       dev_hit, dev_rd;
    regs_t      q, d;

    i2c_line_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({scl_i, sda_i}),
        .q_o   (sync_s)
    );
    assign scl_s = sync_s[1];
    assign sda_s = sync_s[0];

    i2c_bus_events u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    i2c_dev_match u_match (
        .byte_i (q.sh),
        .sel_i  (sel_i),
        .hit_o  (dev_hit),
        .rd_o   (dev_rd)
    );

    always_comb begin
        d     = q;
        d.wr  = 1'b0;
        d.rd  = 1'b0;
        d.rdv = q.rd;
        if (q.rdv) d.txb = mem_rdata_i;

        if (start_ev) begin
            d.st      = ST_DEV;
            d.bcnt    = '0;
            d.in_ack  = 1'b0;
            d.dev_ack = 1'b0;
            d.oe      = 1'b0;
        end else if (stop_ev) begin
            d.st      = ST_IDLE;
            d.bcnt    = '0;
            d.in_ack  = 1'b0;
            d.dev_ack = 1'b0;
            d.oe      = 1'b0;
        end else if (q.st != ST_IDLE) begin
            if (scl_rise) begin
                if (!q.in_ack) begin
                    d.bcnt = q.bcnt + 4'd1;
                    if (q.st != ST_RD) d.sh = {q.sh[6:0], sda_s};
                end else if (q.st == ST_RD && !q.dev_ack) begin
                    // host acknowledge slot of a read byte
                    if (sda_s) begin
                        d.st     = ST_IDLE;
                        d.in_ack = 1'b0;
                    end else begin
                        d.rd    = 1'b1;
                        d.maddr = q.ptr;
                        d.ptr   = q.ptr + 1'b1;
                    end
                end
            end else if (scl_fall) begin
                if (q.in_ack) begin
                    d.in_ack  = 1'b0;
                    d.dev_ack = 1'b0;
                    d.bcnt    = '0;
                    if (q.st == ST_RD) begin
                        d.oe = ~q.txb[7];
                        d.sh = {q.txb[6:0], 1'b0};
                    end else begin
                        d.oe = 1'b0;
                    end
                end else if (q.bcnt == 4'd8) begin
                    if (q.st == ST_RD) begin
                        d.oe      = 1'b0;
                        d.in_ack  = 1'b1;
                        d.dev_ack = 1'b0;
                    end else begin
                        d.in_ack  = 1'b1;
                        d.dev_ack = 1'b1;
                        d.oe      = 1'b1;
                        unique case (q.st)
                            ST_DEV: begin
                                if (!dev_hit) begin
                                    d.st      = ST_IDLE;
                                    d.oe      = 1'b0;
                                    d.in_ack  = 1'b0;
                                    d.dev_ack = 1'b0;
                                end else if (dev_rd) begin
                                    d.st    = ST_RD;
                                    d.rd    = 1'b1;
                                    d.maddr = q.ptr;
                                    d.ptr   = q.ptr + 1'b1;
                                end else begin
                                    d.st = ST_AHI;
                                end
                            end
                            ST_AHI: begin
                                d.ptr[AW-1:8] = q.sh[HI_W-1:0];
                                d.st          = ST_ALO;
                            end
                            ST_ALO: begin
                                d.ptr[7:0] = q.sh;
                                d.st       = ST_WR;
                            end
                            ST_WR: begin
                                d.wr    = 1'b1;
                                d.maddr = q.ptr;
                                d.wdata = q.sh;
                                d.ptr   = q.ptr + 1'b1;
                            end
                            default: ;
                        endcase
                    end
                end else if (q.st == ST_RD) begin
                    d.oe = ~q.sh[7];
                    d.sh = {q.sh[6:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sda_oe_o    = q.oe;
    assign mem_addr_o  = q.maddr;
    assign mem_wr_o    = q.wr;
    assign mem_wdata_o = q.wdata;
    assign mem_rd_o    = q.rd;
endmodule

// File: rtl/i2c_mem_target_chk.sv
module i2c_mem_target_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic sda_oe_o,
    input logic mem_wr_o,
    input logic mem_rd_o,
    input logic start_ev,
    input logic stop_ev
);
    assert_stop_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !sda_oe_o);

    assert_start_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> !sda_oe_o);

    assert_oe_scl_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_i);

    assert_wr_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_o |=> !mem_wr_o);

    assert_rd_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |=> !mem_rd_o);

    assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_wr_o && mem_rd_o));
endmodule

bind i2c_mem_target i2c_mem_target_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_oe_o (sda_oe_o),
    .mem_wr_o (mem_wr_o),
    .mem_rd_o (mem_rd_o),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
);

// File: tb/tb_i2c_mem_target.sv
module tb_i2c_mem_target;
    localparam int H = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_h = 1'b1;
    logic        sda_h = 1'b1;
    logic [2:0]  sel = 3'b101;
    logic        sda_oe_o, mem_wr_o, mem_rd_o;
    logic [14:0] mem_addr_o;
    logic [7:0]  mem_wdata_o;
    logic [7:0]  mem_rdata_i = 8'h00;
    logic        sda_line;
    logic [7:0]  mem [256];
    logic [22:0] exp_q [$];
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;
    assign sda_line = sda_h & ~sda_oe_o;

    i2c_mem_target dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_h),
        .sda_i       (sda_line),
        .sel_i       (sel),
        .sda_oe_o    (sda_oe_o),
        .mem_addr_o  (mem_addr_o),
        .mem_wr_o    (mem_wr_o),
        .mem_wdata_o (mem_wdata_o),
        .mem_rd_o    (mem_rd_o),
        .mem_rdata_i (mem_rdata_i)
    );

    initial for (int i = 0; i < 256; i++) mem[i] = 8'h00;

    always @(posedge clk) begin
        if (mem_wr_o) mem[mem_addr_o[7:0]] <= mem_wdata_o;
        if (mem_rd_o) mem_rdata_i <= mem[mem_addr_o[7:0]];
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // scoreboard monitor for memory writes (R4, R3)
    always @(negedge clk) begin
        if (rst_n && mem_wr_o) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3 unexpected write", {9'd0, mem_addr_o, mem_wdata_o}, 32'h0);
            end else begin
                logic [22:0] e;
                e = exp_q.pop_front();
                check({mem_addr_o, mem_wdata_o} == e, "R4 write addr/data",
                      {9'd0, mem_addr_o, mem_wdata_o}, {9'd0, e});
            end
        end
    end

    task automatic wc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        wc(5); sda_h = 1'b1; wc(5);
        scl_h = 1'b1; wc(H);
        sda_h = 1'b0; wc(H);
        scl_h = 1'b0;
    endtask

    task automatic bus_stop;
        wc(5); sda_h = 1'b0; wc(H);
        scl_h = 1'b1; wc(H);
        sda_h = 1'b1; wc(H);
    endtask

    task automatic send_bit(input bit b);
        wc(5); sda_h = b; wc(H - 5);
        scl_h = 1'b1; wc(H);
        scl_h = 1'b0;
    endtask

    task automatic get_bit(output bit b);
        wc(5); sda_h = 1'b1; wc(H - 5);
        scl_h = 1'b1; wc(H / 2);
        b = sda_line; wc(H / 2);
        scl_h = 1'b0;
    endtask

    task automatic tx(input logic [7:0] v, input bit exp_ack, input string req);
        bit b;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        get_bit(b);
        check((!b) == exp_ack, req, {31'd0, !b}, {31'd0, exp_ack});
    endtask

    task automatic rx(input logic [7:0] exp, input bit give_ack, input string req);
        logic [7:0] v;
        bit b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        send_bit(!give_ack);
        check(v == exp, req, {24'd0, v}, {24'd0, exp});
    endtask

    task automatic push_w(input logic [14:0] a, input logic [7:0] v);
        exp_q.push_back({a, v});
    endtask

    initial begin
        wc(10);
        check(sda_oe_o == 1'b0, "R8 reset oe", {31'd0, sda_oe_o}, 32'd0);
        check(mem_wr_o == 1'b0 && mem_rd_o == 1'b0, "R9 reset strobes",
              {30'd0, mem_wr_o, mem_rd_o}, 32'd0);
        rst_n = 1'b1;
        wc(10);

        // R4: write three bytes at 0x1234
        bus_start;
        tx(8'hAA, 1'b1, "R3 address match ack");
        tx(8'h12, 1'b1, "R4 addr hi ack");
        tx(8'h34, 1'b1, "R4 addr lo ack");
        push_w(15'h1234, 8'h11); tx(8'h11, 1'b1, "R4 data ack");
        push_w(15'h1235, 8'h22); tx(8'h22, 1'b1, "R4 data ack");
        push_w(15'h1236, 8'h33); tx(8'h33, 1'b1, "R4 data ack");
        bus_stop;
        wc(2);
        check(sda_oe_o == 1'b0, "R1 released after stop", {31'd0, sda_oe_o}, 32'd0);

        // R5: random read at 0x1234 with a repeated start
        bus_start;
        tx(8'hAA, 1'b1, "R5 write-dir address");
        tx(8'h12, 1'b1, "R5 addr hi");
        tx(8'h34, 1'b1, "R5 addr lo");
        bus_start;
        tx(8'hAB, 1'b1, "R5 read address ack");
        rx(8'h11, 1'b1, "R5 first read byte");
        rx(8'h22, 1'b0, "R5 second read byte");
        wc(H);
        check(sda_oe_o == 1'b0, "R5 released after host nack", {31'd0, sda_oe_o}, 32'd0);
        bus_stop;

        // R7: current-address read continues at 0x1236
        bus_start;
        tx(8'hAB, 1'b1, "R7 read address ack");
        rx(8'h33, 1'b0, "R7 current address byte");
        bus_stop;

        // R6 and R4 top bit ignored: write across the wrap point
        bus_start;
        tx(8'hAA, 1'b1, "R6 address ack");
        tx(8'hFF, 1'b1, "R4 hi byte with top bit set");
        tx(8'hFF, 1'b1, "R6 lo byte");
        push_w(15'h7FFF, 8'h5A); tx(8'h5A, 1'b1, "R6 data at 7FFF");
        push_w(15'h0000, 8'hA5); tx(8'hA5, 1'b1, "R6 data after wrap");
        bus_stop;
        bus_start;
        tx(8'hAA, 1'b1, "R6 address ack");
        tx(8'h7F, 1'b1, "R6 addr hi");
        tx(8'hFF, 1'b1, "R6 addr lo");
        bus_start;
        tx(8'hAB, 1'b1, "R6 read address ack");
        rx(8'h5A, 1'b1, "R6 read at 7FFF");
        rx(8'hA5, 1'b0, "R6 read wrapped to 0000");
        bus_stop;

        // R3: wrong select bits and wrong device type are ignored
        bus_start;
        tx(8'hA6, 1'b0, "R3 select mismatch nack");
        tx(8'h00, 1'b0, "R3 ignored byte");
        tx(8'h30, 1'b0, "R3 ignored byte");
        tx(8'h99, 1'b0, "R3 ignored byte");
        bus_stop;
        bus_start;
        tx(8'hBA, 1'b0, "R3 type mismatch nack");
        tx(8'h00, 1'b0, "R3 ignored byte");
        bus_stop;

        // R2: start in the middle of the low address byte
        bus_start;
        tx(8'hAA, 1'b1, "R2 address ack");
        tx(8'h00, 1'b1, "R2 addr hi");
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        bus_start;
        tx(8'hAA, 1'b1, "R2 address after abort");
        tx(8'h00, 1'b1, "R2 addr hi");
        tx(8'h10, 1'b1, "R2 addr lo");
        push_w(15'h0010, 8'h77); tx(8'h77, 1'b1, "R2 data after abort");
        bus_stop;

        // R2: stop in the middle of a data byte writes nothing
        bus_start;
        tx(8'hAA, 1'b1, "R2 address ack");
        tx(8'h00, 1'b1, "R2 addr hi");
        tx(8'h20, 1'b1, "R2 addr lo");
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        bus_stop;
        check(sda_oe_o == 1'b0, "R2 released after stop abort", {31'd0, sda_oe_o}, 32'd0);
        bus_start;
        tx(8'hAA, 1'b1, "R2 address ack");
        tx(8'h00, 1'b1, "R2 addr hi");
        tx(8'h20, 1'b1, "R2 addr lo");
        bus_start;
        tx(8'hAB, 1'b1, "R2 read address ack");
        rx(8'h00, 1'b0, "R2 aborted byte not stored");
        bus_stop;

        wc(20);
        check(exp_q.size() == 0, "R4 all writes seen", exp_q.size(), 32'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog actual=timeout expected=done");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule